// File: doc/BRIEF.md
# Two-Digit BCD Seconds Countdown

This block is a seconds countdown held as two BCD digits, a ones digit and a tens digit. A reload request presets the count to 60. After that, each clean one-cycle tick strobe that arrives while the run level is high takes one second off the count. When the ones digit passes below zero it wraps to nine and borrows one from the tens digit in the same clock edge. When both digits reach zero the count enable is forced off, so the display stays at 00 until the next reload.

The block drives two digit values, a done flag and one registered seven-segment pattern per digit. The segment patterns are active-low, for common-anode displays. The tick strobe comes from a divider outside this block. Button conditioning and display multiplexing are also handled elsewhere.

Top module: `sec_countdown`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is tens = 6 and ones = 0, `done` = 0, and both segment outputs are all ones (blank). Reset is synchronous and active-low.
- R2: A cycle with `tick`=1, `run`=1, no reload and a count other than 00 lowers the ones digit by one at that edge. A cycle with `tick`=0 leaves both digits unchanged.
- R3: A counting tick that finds the ones digit at 0 sets it to 9 and lowers the tens digit by one at the same edge.
- R4: From the preset, 60 counting ticks step the digits through 59, 58, … down to 00, one value per tick. The tens digit never exceeds 6 and the ones digit never exceeds 9.
- R5: At 00, ticks have no effect whatever the `run` level. The digits stay at 00 and `done` stays high until a reload.
- R6: While `run` is 0, ticks are ignored and the count holds its value.
- R7: `reload`=1 at a clock edge loads tens = 6 and ones = 0 (binary 0110 and 0000). This takes priority over a tick in the same cycle.
- R8: A reload leaves the run level untouched. If `run` stays high, the first tick after the reload gives 59.
- R9: `done` is 1 exactly when both digits are 0, and it drops at the edge that reloads.
- R10: Each segment output is registered and reflects the digit value one clock after that value appears. Bit 0 is segment a and bit 6 is segment g. A 0 lights a segment. The patterns for digits 0–9, written as bits 6..0, are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, presets 60 |
| tick | input | 1 | One-cycle seconds strobe |
| run | input | 1 | Level: 1 counts, 0 pauses |
| reload | input | 1 | Synchronous request to preset 60 |
| tens_bcd | output | 4 | Tens digit, BCD |
| ones_bcd | output | 4 | Ones digit, BCD |
| done | output | 1 | High while the count reads 00 |
| tens_seg_n | output | 7 | Active-low segments for tens, bit 0 = a |
| ones_seg_n | output | 7 | Active-low segments for ones, bit 0 = a |

## Verification
The assertions assume a tick that is already a clean strobe synchronous to `clk`. They also assume that `run` and `reload` change only between edges, so the value sampled at an edge is the one that was intended. The bench drives every input on the falling edge and samples on the next falling edge. Random stimulus keeps reload rare, so that long countdowns reach 00 and hold there, while ticks and run toggle freely. Directed cases cover a reload and a tick in the same cycle, the pause, and the full run from 60 to 00.

// File: rtl/cdt_pkg.sv
// Shared widths, types and the seven-segment table for the seconds countdown.
// Assumes one BCD digit per four bits and seven segments ordered a (bit 0) to g.
package cdt_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;

    localparam seg_t SEG_BLANK = '1;

    // Active-low pattern for one BCD value; codes above 9 blank the digit.
    function automatic seg_t seg_of(input bcd_t v);
        seg_t lit;
        case (v)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction
endpackage

// File: rtl/cdt_digit.sv
// One BCD down-counting digit with a synchronous preset.
// Counts down by one when dec is high. Below zero it wraps to TOP_VAL and
// raises borrow in the same cycle. load has priority over dec.
// Assumes LOAD_VAL and TOP_VAL fit in one BCD digit.
module cdt_digit
    import cdt_pkg::*;
#(
    parameter int TOP_VAL  = 9,
    parameter int LOAD_VAL = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output bcd_t q,
    output logic borrow
);
    localparam bcd_t TOP  = bcd_t'(TOP_VAL);
    localparam bcd_t INIT = bcd_t'(LOAD_VAL);

    // Borrow toward the next digit when a decrement finds this digit at zero.
    assign borrow = dec && !load && (q == '0);

    // Digit register: preset on reset or load, otherwise step down with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            q <= INIT;
        end else if (dec) begin
            q <= (q == '0) ? TOP : q - 1'b1;
        end
    end

    // R3: a decrement at zero wraps to the top value.
    assert_digit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && q == '0) |=> (q == TOP));

    // R2: a decrement above zero lowers the digit by exactly one.
    assert_digit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && q != '0) |=> (q == $past(q) - 1'b1));

    // R7: load wins over a decrement in the same cycle.
    assert_digit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == INIT));
endmodule

// File: rtl/cdt_seg_enc.sv
// Registered active-low seven-segment encoder for one BCD digit.
// The output follows the input one clock later and is blank during reset.
module cdt_seg_enc
    import cdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  bcd_t bcd,
    output seg_t seg_n
);
    // Pattern register: blank under reset, else encode the current digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_n <= SEG_BLANK;
        end else begin
            seg_n <= seg_of(bcd);
        end
    end

    // R10: a digit that holds for two edges leaves the pattern unchanged.
    assert_seg_settled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd <= 4'd9 && $past(rst_n) && $stable(bcd)) |=> $stable(seg_n));
endmodule

// File: rtl/sec_countdown.sv
// Two-digit BCD seconds countdown that presets to a fixed value and halts at 00.
// The ones digit borrows from the tens digit. The zero detector gates the
// count enable, so ticks are ignored at 00. Assumes tick is a clean one-cycle
// strobe synchronous to clk.
module sec_countdown
    import cdt_pkg::*;
#(
    parameter int PRESET_TENS = 6,
    parameter int PRESET_ONES = 0,
    parameter int TENS_TOP    = 5,
    parameter int ONES_TOP    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             reload,
    output logic [DIGIT_W-1:0] tens_bcd,
    output logic [DIGIT_W-1:0] ones_bcd,
    output logic             done,
    output logic [SEG_W-1:0] tens_seg_n,
    output logic [SEG_W-1:0] ones_seg_n
);
    localparam int NUM_DIGITS = 2;

    logic count_en;
    logic ones_borrow;
    logic tens_borrow;
    bcd_t digit_q [NUM_DIGITS];
    seg_t digit_seg [NUM_DIGITS];

    // Zero detect: both digits read zero.
    assign done = (digit_q[0] == '0) && (digit_q[1] == '0);

    // Count enable: a tick while running, suppressed once the count is 00.
    assign count_en = tick && run && !done;

    cdt_digit #(.TOP_VAL(ONES_TOP), .LOAD_VAL(PRESET_ONES)) u_ones (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (reload),
        .dec    (count_en),
        .q      (digit_q[0]),
        .borrow (ones_borrow)
    );

    cdt_digit #(.TOP_VAL(TENS_TOP), .LOAD_VAL(PRESET_TENS)) u_tens (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (reload),
        .dec    (ones_borrow),
        .q      (digit_q[1]),
        .borrow (tens_borrow)
    );

    // One registered encoder per digit.
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_seg
        cdt_seg_enc u_enc (
            .clk   (clk),
            .rst_n (rst_n),
            .bcd   (digit_q[d]),
            .seg_n (digit_seg[d])
        );
    end

    assign ones_bcd   = digit_q[0];
    assign tens_bcd   = digit_q[1];
    assign ones_seg_n = digit_seg[0];
    assign tens_seg_n = digit_seg[1];

    // R1/R7: a reload presets the count on the following edge.
    assert_reload_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (tens_bcd == bcd_t'(PRESET_TENS) && ones_bcd == bcd_t'(PRESET_ONES)));

    // R5: at 00 the count stays at 00 until a reload.
    assert_hold_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reload) |=> done);

    // R6: with run low the digits do not move.
    assert_pause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> ($stable(tens_bcd) && $stable(ones_bcd)));

    // R4: both digits stay within their ranges.
    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tens_bcd <= bcd_t'(PRESET_TENS) && ones_bcd <= bcd_t'(ONES_TOP)));

    // R5: the tens digit never borrows, since 00 disables counting.
    assert_no_tens_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tens_borrow);

    // R9: done drops at the edge that reloads.
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !done);
endmodule

// File: tb/sec_countdown_test.sv
`timescale 1ns/1ps
module sec_countdown_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic run = 1'b0;
    logic reload = 1'b0;
    logic [3:0] tens_bcd;
    logic [3:0] ones_bcd;
    logic done;
    logic [6:0] tens_seg_n;
    logic [6:0] ones_seg_n;

    int checks = 0;
    int fails = 0;

    // Reference state, updated from the requirements.
    int m_t = 6;
    int m_o = 0;
    logic [6:0] m_st = 7'h7F;
    logic [6:0] m_so = 7'h7F;

    always #4 clk = ~clk;

    sec_countdown uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .reload(reload),
        .tens_bcd(tens_bcd), .ones_bcd(ones_bcd), .done(done),
        .tens_seg_n(tens_seg_n), .ones_seg_n(ones_seg_n)
    );

    // Expected segment pattern from the R10 table (bit 6 = g ... bit 0 = a).
    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'b1000000;
            1: return 7'b1111001;
            2: return 7'b0100100;
            3: return 7'b0110000;
            4: return 7'b0011001;
            5: return 7'b0010010;
            6: return 7'b0000010;
            7: return 7'b1111000;
            8: return 7'b0000000;
            9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference step for one clock edge.
    task automatic model_step();
        logic [6:0] nt, no;
        nt = pat(m_t);
        no = pat(m_o);
        if (!rst_n) begin
            m_t = 6; m_o = 0; m_st = 7'h7F; m_so = 7'h7F;
        end else begin
            m_st = nt; m_so = no;
            if (reload) begin
                m_t = 6; m_o = 0;
            end else if (tick && run && !(m_t == 0 && m_o == 0)) begin
                if (m_o == 0) begin m_o = 9; m_t = m_t - 1; end
                else m_o = m_o - 1;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " tens"}, int'(tens_bcd), m_t);
        chk({tag, " ones"}, int'(ones_bcd), m_o);
        chk({tag, " done"}, int'(done), int'(m_t == 0 && m_o == 0));
        chk({tag, " tens_seg"}, int'(tens_seg_n), int'(m_st));
        chk({tag, " ones_seg"}, int'(ones_seg_n), int'(m_so));
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic cyc(input logic tk, input logic rn, input logic rl, input string tag);
        tick = tk; run = rn; reload = rl;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        @(negedge clk);
        // R1: reset state.
        rst_n = 1'b0;
        cyc(1, 1, 0, "R1");
        cyc(1, 1, 0, "R1");
        rst_n = 1'b1;
        // R10: segments show 60 one cycle after reset.
        cyc(0, 0, 0, "R10");
        // R8: reload with run already high, then first tick gives 59 (R3 borrow).
        cyc(0, 1, 1, "R8");
        cyc(1, 1, 0, "R3/R8");
        chk("R3 tens", int'(tens_bcd), 5);
        chk("R3 ones", int'(ones_bcd), 9);
        // R6: paused ticks.
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R6");
        // R2: no tick, then one tick.
        cyc(0, 1, 0, "R2");
        cyc(1, 1, 0, "R2");
        // R4: run down to 00.
        for (int i = 0; i < 58; i++) cyc(1, 1, 0, "R4");
        chk("R4 at 00", int'(tens_bcd) * 10 + int'(ones_bcd), 0);
        chk("R9 done at 00", int'(done), 1);
        // R5: ticks at 00 ignored.
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, "R5");
        cyc(1, 0, 0, "R5");
        // R7: reload beats tick, done clears (R9).
        cyc(1, 1, 1, "R7/R9");
        chk("R7 preset", int'(tens_bcd) * 10 + int'(ones_bcd), 60);
        chk("R9 cleared", int'(done), 0);
        // Random mix (R2 and all others via the reference).
        for (int i = 0; i < 3000; i++) begin
            logic tk, rn, rl;
            tk = ($urandom % 2) == 0;
            rn = ($urandom % 8) != 0;
            rl = ($urandom % 96) == 0;
            cyc(tk, rn, rl, "R2 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule